// File: doc/BRIEF.md
# Codeword Buffer Region Drain Engine

This block empties a byte buffer that a flash controller has filled with one codeword, and sends selected parts of it to a memory-side byte stream. It does not copy the whole buffer in order. Software first writes up to four read-location entries through a register write port. Each entry gives a start offset in the buffer, a byte count and a flag that marks it as the final request. A start pulse, accepted only while the buffer is reported full, takes a snapshot of the entries. The engine then walks them from the lowest index upwards and streams each region through a valid/ready byte interface.

When the flagged entry has been fully consumed downstream, the engine releases the buffer with a one-cycle pulse. A region that runs past the end of the buffer also ends the drain, as does a table in which no entry carries the final flag. In both cases an error level is raised, and it stays up until the next accepted start. The buffer is read through a synchronous port with one cycle of latency. A small queue at the output keeps one byte per cycle flowing while the consumer is ready.

Top module: `cwbuf_drain`

## Requirements
- R1: The entries sit at register addresses LOC_BASE + 4*i (0xF20, 0xF24, 0xF28, 0xF2C by default). In each 32-bit entry word, bits 15:0 are the byte offset, bits 30:16 are the byte count and bit 31 is the final flag.
- R2: Entries are processed in ascending index order. Each one emits exactly count bytes, taken from buffer addresses offset, offset+1, and so on in that order. Regions placed back to back (two or four entries) come out concatenated.
- R3: Once the flagged entry has been consumed, buf_release pulses high for exactly one cycle and busy is low. Entries after the flagged one produce no bytes.
- R4: An entry with a count of zero produces no bytes, and processing moves on to the next entry.
- R5: An entry whose offset + count exceeds DEPTH produces no bytes. It sets err, and the drain ends with a buf_release pulse.
- R6: If entries 0 to NUM_LOC-1 finish without any final flag, all of their bytes are emitted, then err is set and buf_release pulses.
- R7: start is ignored while buf_full is low or while a drain is in progress.
- R8: Entry writes made during a drain are stored, but they affect only the next accepted start.
- R9: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change.
- R10: With out_ready held high, a single region of N bytes is drained and released within N + 10 cycles of start.
- R11: After reset, busy, out_valid, err and buf_release are all low. err is cleared when a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | REG_AW (12) | Register byte address |
| reg_wr_data | input | 32 | Entry word |
| buf_full | input | 1 | Buffer holds a codeword |
| start | input | 1 | Begin a drain |
| buf_rd_en | output | 1 | Buffer read request |
| buf_rd_addr | output | $clog2(DEPTH) (10) | Buffer read address |
| buf_rd_data | input | 8 | Buffer read data, one cycle after request |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts byte |
| out_data | output | 8 | Output byte |
| busy | output | 1 | Drain in progress |
| buf_release | output | 1 | One-cycle pulse: buffer emptied |
| err | output | 1 | Range error or missing final flag |

## Verification
The bench builds the block with its default parameters: a 1024-byte buffer, four entries and a two-deep output queue. The buffer depth makes a full 512-byte region possible, along with regions that end exactly on the last byte or just past it. The two-deep queue is the smallest that allows the one-byte-per-cycle rate checked under R10. With a random ready signal, that same queue is forced through its full, stall and refill states.

// File: rtl/cwd_pkg.sv
package cwd_pkg;
   localparam int LOC_OFF_W = 16;
   localparam int LOC_CNT_W = 15;

   typedef struct packed {
      logic                 fin;
      logic [LOC_CNT_W-1:0] cnt;
      logic [LOC_OFF_W-1:0] off;
   } loc_entry_t;

   typedef enum logic [1:0] {
      WS_IDLE   = 2'd0,
      WS_FETCH  = 2'd1,
      WS_STREAM = 2'd2,
      WS_DRAIN  = 2'd3
   } walk_state_t;
endpackage

// File: rtl/cwd_locregs.sv
module cwd_locregs
   import cwd_pkg::*;
#(
   parameter int               NUM_LOC  = 4,
   parameter int               REG_AW   = 12,
   parameter logic [REG_AW-1:0] LOC_BASE = 12'hF20
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [REG_AW-1:0]         wr_addr,
   input  logic [31:0]               wr_data,
   input  logic                      snap,
   output loc_entry_t [NUM_LOC-1:0]  work
);
   loc_entry_t [NUM_LOC-1:0] prog;

   for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
      localparam logic [REG_AW-1:0] MY_ADDR = REG_AW'(int'(LOC_BASE) + 4 * i);
      logic hit;
      assign hit = wr_en && (wr_addr == MY_ADDR);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prog[i] <= '0;
            work[i] <= '0;
         end else begin
            if (hit)  prog[i] <= loc_entry_t'(wr_data);
            if (snap) work[i] <= prog[i];
         end
      end

      // R8: working copy moves only on an accepted start
      p_work_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
         !snap |=> $stable(work[i]));
   end
endmodule

// File: rtl/cwd_outq.sv
module cwd_outq #(
   parameter int W     = 8,
   parameter int DEPTH = 2,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  push_data,
   input  logic          pop,
   output logic          valid,
   output logic [W-1:0]  head,
   output logic [CW-1:0] cnt
);
   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) begin
            mem[wp] <= push_data;
            wp      <= nxt(wp);
         end
         if (pop) rp <= nxt(rp);
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign valid = (cnt != '0);
   assign head  = mem[rp];

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (cnt < CW'(DEPTH)) || pop);
   p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !pop) |=> valid && $stable(head));
endmodule

// File: rtl/cwd_walker.sv
module cwd_walker
   import cwd_pkg::*;
#(
   parameter int NUM_LOC = 4,
   parameter int DEPTH   = 1024,
   localparam int IDX_W  = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1,
   localparam int BUF_AW = $clog2(DEPTH),
   localparam int SUM_W  = LOC_OFF_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     go,
   input  loc_entry_t [NUM_LOC-1:0] locs,
   input  logic                     can_issue,
   input  logic                     out_idle,
   output logic                     rd_en,
   output logic [BUF_AW-1:0]        rd_addr,
   output logic                     busy,
   output logic                     release_p,
   output logic                     err
);
   walk_state_t          st;
   logic [IDX_W-1:0]     idx;
   logic [BUF_AW-1:0]    ptr;
   logic [LOC_CNT_W-1:0] rem;
   loc_entry_t           cur;
   logic [SUM_W-1:0]     span_end;
   logic                 over, at_top;

   assign cur      = locs[idx];
   assign span_end = SUM_W'(cur.off) + SUM_W'(cur.cnt);
   assign over     = span_end > SUM_W'(DEPTH);
   assign at_top   = (idx == IDX_W'(NUM_LOC - 1));
   assign rd_en    = (st == WS_STREAM) && can_issue;
   assign rd_addr  = ptr;
   assign busy     = (st != WS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= WS_IDLE;
         idx       <= '0;
         ptr       <= '0;
         rem       <= '0;
         release_p <= 1'b0;
         err       <= 1'b0;
      end else begin
         release_p <= 1'b0;
         unique case (st)
            WS_IDLE: if (go) begin
               idx <= '0;
               err <= 1'b0;
               st  <= WS_FETCH;
            end
            WS_FETCH: begin
               if (over) begin
                  err <= 1'b1;
                  st  <= WS_DRAIN;
               end else if (cur.cnt == '0) begin
                  if (cur.fin)     st <= WS_DRAIN;
                  else if (at_top) begin
                     err <= 1'b1;
                     st  <= WS_DRAIN;
                  end else idx <= idx + 1'b1;
               end else begin
                  ptr <= cur.off[BUF_AW-1:0];
                  rem <= cur.cnt;
                  st  <= WS_STREAM;
               end
            end
            WS_STREAM: if (rd_en) begin
               ptr <= ptr + 1'b1;
               rem <= rem - 1'b1;
               if (rem == LOC_CNT_W'(1)) begin
                  if (cur.fin)     st <= WS_DRAIN;
                  else if (at_top) begin
                     err <= 1'b1;
                     st  <= WS_DRAIN;
                  end else begin
                     idx <= idx + 1'b1;
                     st  <= WS_FETCH;
                  end
               end
            end
            WS_DRAIN: if (out_idle) begin
               release_p <= 1'b1;
               st        <= WS_IDLE;
            end
            default: st <= WS_IDLE;
         endcase
      end
   end

   p_release_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      release_p |=> !release_p);
   p_release_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      release_p |-> !busy);
   p_err_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !err);
   p_idle_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !rd_en);
endmodule

// File: rtl/cwbuf_drain.sv
module cwbuf_drain
   import cwd_pkg::*;
#(
   parameter int               DEPTH      = 1024,
   parameter int               NUM_LOC    = 4,
   parameter int               REG_AW     = 12,
   parameter logic [REG_AW-1:0] LOC_BASE  = 12'hF20,
   parameter int               FIFO_DEPTH = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr_en,
   input  logic [REG_AW-1:0]        reg_wr_addr,
   input  logic [31:0]              reg_wr_data,
   input  logic                     buf_full,
   input  logic                     start,
   output logic                     buf_rd_en,
   output logic [$clog2(DEPTH)-1:0] buf_rd_addr,
   input  logic [7:0]               buf_rd_data,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [7:0]               out_data,
   output logic                     busy,
   output logic                     buf_release,
   output logic                     err
);
   localparam int QCW   = $clog2(FIFO_DEPTH + 1);
   localparam int OCC_W = QCW + 2;

   if (DEPTH < 2 || DEPTH > (1 << LOC_OFF_W)) begin : g_bad_depth
      $error("DEPTH must lie in 2..65536");
   end
   if (NUM_LOC < 1) begin : g_bad_loc
      $error("NUM_LOC must be at least 1");
   end
   if (FIFO_DEPTH < 2) begin : g_bad_q
      $error("FIFO_DEPTH must be at least 2 for full rate");
   end

   loc_entry_t [NUM_LOC-1:0] locs;
   logic                     go, pend, pop, can_issue, out_idle;
   logic [QCW-1:0]           q_cnt;
   logic [OCC_W-1:0]         occ;

   assign go  = start && buf_full && !busy;
   assign pop = out_valid && out_ready;
   assign occ = OCC_W'(q_cnt) + OCC_W'(pend);
   assign can_issue = occ < (OCC_W'(FIFO_DEPTH) + OCC_W'(pop));
   assign out_idle  = (q_cnt == '0) && !pend;

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= 1'b0;
      else        pend <= buf_rd_en;
   end

   cwd_locregs #(.NUM_LOC(NUM_LOC), .REG_AW(REG_AW), .LOC_BASE(LOC_BASE)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .wr_addr(reg_wr_addr),
      .wr_data(reg_wr_data), .snap(go), .work(locs));

   cwd_walker #(.NUM_LOC(NUM_LOC), .DEPTH(DEPTH)) u_walk (
      .clk(clk), .rst_n(rst_n), .go(go), .locs(locs), .can_issue(can_issue),
      .out_idle(out_idle), .rd_en(buf_rd_en), .rd_addr(buf_rd_addr),
      .busy(busy), .release_p(buf_release), .err(err));

   cwd_outq #(.W(8), .DEPTH(FIFO_DEPTH)) u_q (
      .clk(clk), .rst_n(rst_n), .push(pend), .push_data(buf_rd_data),
      .pop(pop), .valid(out_valid), .head(out_data), .cnt(q_cnt));

   p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !buf_full && !busy) |=> !busy);
   p_release_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_release |-> !out_valid);
endmodule

// File: tb/cwbuf_drain_test.sv
module cwbuf_drain_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [11:0] reg_wr_addr = '0;
   logic [31:0] reg_wr_data = '0;
   logic        buf_full = 1'b0;
   logic        start = 1'b0;
   logic        buf_rd_en;
   logic [9:0]  buf_rd_addr;
   logic [7:0]  buf_rd_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [7:0]  out_data;
   logic        busy, buf_release, err;

   always #2.5 clk = ~clk;

   cwbuf_drain uut (.*);

   logic [7:0] mem [1024];
   always @(posedge clk) if (buf_rd_en) buf_rd_data <= mem[buf_rd_addr];

   int n_chk = 0, n_bad = 0, cyc = 0, rel_cnt = 0, stall_bad = 0;
   bit ready_always = 1'b1, prev_stall = 1'b0, rel_err = 1'b0;
   logic [7:0] prev_data = '0;
   logic [7:0] got [$];
   logic [7:0] exp_q [$];
   bit exp_err;
   int e_off [4], e_cnt [4];
   bit e_fin [4];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (prev_stall && !(out_valid && out_data == prev_data)) stall_bad++;
      out_ready = ready_always ? 1'b1 : (($urandom % 4) != 0);
      if (out_valid && out_ready) got.push_back(out_data);
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (buf_release) begin
         rel_cnt++;
         rel_err = err;
      end
      if (cyc > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   task automatic wr(input int i, input int off, input int cnt, input bit fin);
      @(negedge clk);
      reg_wr_en   = 1'b1;
      reg_wr_addr = 12'(12'hF20 + 4 * i);
      reg_wr_data = {fin, 15'(cnt), 16'(off)};
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic prog(input int i, input int off, input int cnt, input bit fin);
      e_off[i] = off; e_cnt[i] = cnt; e_fin[i] = fin;
      wr(i, off, cnt, fin);
   endtask

   function automatic void build_exp();
      exp_q.delete();
      exp_err = 1'b0;
      for (int i = 0; i < 4; i++) begin
         if (e_off[i] + e_cnt[i] > 1024) begin exp_err = 1'b1; return; end
         for (int k = 0; k < e_cnt[i]; k++) exp_q.push_back(mem[e_off[i] + k]);
         if (e_fin[i]) return;
         if (i == 3) exp_err = 1'b1;
      end
   endfunction

   task automatic fill();
      for (int a = 0; a < 1024; a++) mem[a] = 8'($urandom);
   endtask

   task automatic pulse_start();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
   endtask

   // returns cycles from start to release
   task automatic drain(output int took);
      int t0, r0;
      got.delete();
      r0 = rel_cnt;
      buf_full = 1'b1;
      t0 = cyc;
      pulse_start();
      while (rel_cnt == r0 && cyc - t0 < 5000) @(negedge clk);
      took = cyc - t0;
      @(negedge clk);
   endtask

   task automatic compare(input string tag);
      bit same;
      same = (got.size() == exp_q.size());
      if (same) foreach (got[k]) if (got[k] !== exp_q[k]) same = 1'b0;
      check(got.size() == exp_q.size(), {tag, " byte count"}, got.size(), exp_q.size());
      check(same, {tag, " byte content"}, same, 1);
      check(rel_err == exp_err, {tag, " err"}, rel_err, exp_err);
   endtask

   initial begin
      int took;
      fill();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(!busy && !out_valid && !err && !buf_release, "R11 reset state",
            {busy, out_valid, err, buf_release}, 0);

      // R1 R2 R10: single region 0..511, full rate
      prog(0, 0, 512, 1);
      build_exp();
      drain(took);
      compare("R2 single 512");
      check(took <= 512 + 10, "R10 throughput", took, 522);
      check(rel_cnt == 1, "R3 one release", rel_cnt, 1);
      check(!busy, "R3 idle after release", busy, 0);

      ready_always = 1'b0;
      // R2 two regions, data then spare
      prog(0, 0, 500, 0); prog(1, 500, 28, 1);
      build_exp(); drain(took); compare("R2 two region");

      // R2 four cumulative regions, entry 3 ends at last byte
      prog(0, 0, 300, 0); prog(1, 300, 200, 0); prog(2, 500, 500, 0); prog(3, 1000, 24, 1);
      build_exp(); drain(took); compare("R2 four region");

      // R3 entries after the flagged one are not read
      prog(0, 40, 16, 0); prog(1, 900, 8, 1); prog(2, 0, 50, 0); prog(3, 60, 9, 1);
      build_exp(); drain(took); compare("R3 stop at final");

      // R4 zero count skipped
      prog(0, 77, 0, 0); prog(1, 10, 5, 0); prog(2, 3, 0, 0); prog(3, 200, 7, 1);
      build_exp(); drain(took); compare("R4 zero count");

      // R5 range overflow on entry 1
      prog(0, 100, 6, 0); prog(1, 1000, 30, 1);
      build_exp(); drain(took); compare("R5 overflow");
      check(err, "R5 err level", err, 1);

      // R11 err cleared by next start
      prog(0, 5, 3, 1);
      build_exp(); drain(took); compare("R11 err cleared");
      check(!err, "R11 err low", err, 0);

      // R6 no final flag anywhere
      prog(0, 1, 4, 0); prog(1, 9, 4, 0); prog(2, 0, 0, 0); prog(3, 1020, 4, 0);
      build_exp(); drain(took); compare("R6 missing final");

      // R7 start ignored without buf_full
      begin
         int r0;
         r0 = rel_cnt; got.delete();
         buf_full = 1'b0;
         pulse_start();
         repeat (6) @(negedge clk);
         check(!busy && rel_cnt == r0 && got.size() == 0, "R7 start gated",
               busy, 0);
      end

      // R8 writes during drain, plus R7 start while busy
      prog(0, 0, 400, 1);
      build_exp();
      got.delete();
      begin
         int r0;
         r0 = rel_cnt;
         buf_full = 1'b1;
         pulse_start();
         wr(0, 600, 3, 1);
         pulse_start();
         while (rel_cnt == r0) @(negedge clk);
         @(negedge clk);
         compare("R8 old snapshot");
         repeat (5) @(negedge clk);
         check(rel_cnt == r0 + 1, "R7 start while busy", rel_cnt - r0, 1);
      end
      e_off[0] = 600; e_cnt[0] = 3; e_fin[0] = 1;
      build_exp(); drain(took); compare("R8 new snapshot");

      // random mix, R2 R3 R4 R5 R6
      for (int it = 0; it < 20; it++) begin
         fill();
         for (int i = 0; i < 4; i++) begin
            int cnt;
            cnt = (($urandom % 5) == 0) ? 0 : int'($urandom % 200);
            prog(i, int'($urandom % 1000), cnt, (($urandom % 3) == 0));
         end
         build_exp(); drain(took); compare("R2 random");
      end

      check(stall_bad == 0, "R9 hold while stalled", stall_bad, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
   end
endmodule